// File: doc/BRIEF.md
# Dynamic Bus Width Adapter with Lane Parity

This block sits between an internal 32-bit requester and an external data bus. The bus can address ports that are 8, 16 or 32 bits wide. For each access the requester gives the transfer size (byte, halfword or word) and the width of the port being addressed. The adapter splits the transfer into as many narrower beats as the port needs. Each beat carries its own address, byte-lane mask and steered write data. Read bytes are collected back into a single 32-bit result.

On every beat the adapter produces one parity bit per active byte lane for writes. It checks the returned parity bit of each active lane on reads. The parity sense, odd or even, is chosen for each access. A parity mismatch sets a sticky error flag and accumulates the mask of failing lanes. When the last beat is acknowledged, a one-cycle completion pulse is raised, and the assembled read data is valid in that same cycle.

Top module: `dbus_sizer`

## Requirements
- R1: While reset is asserted and after it is released, with no request pending, `bus_valid`, `done` and `par_err` are 0, `par_err_lanes` is 0 and `bus_lanes` is 0.
- R2: A request presented with `req_valid` while no transfer is in progress is accepted on the clock edge. Its first beat appears on the bus in the following cycle. A request presented while a transfer is in progress is ignored and does not disturb the current beat.
- R3: The encoding of `req_size` is 0 = byte, 1 = halfword, 2 or 3 = word. The encoding of `port_width` is 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. The number of beats is the transfer size in bytes divided by the port size in bytes, with a minimum of one.
- R4: The start address is the request address with its low bits cleared to the natural alignment of the size (bit 0 for halfwords, bits 1:0 for words). Beat j drives `bus_addr` = start + j × port bytes.
- R5: Byte lane k is bits [8k+7:8k] of `bus_wdata`/`bus_rdata`, and it is bit k of `bus_lanes` and of the parity vectors. A byte at offset o within its 32-bit word travels on lane 3 − (o mod port bytes). Only the lanes of the bytes moved in the beat are set in `bus_lanes`.
- R6: `req_wdata` and `rd_data` hold the byte at word offset o in lane 3 − o. On writes, each active bus lane carries the matching request byte, and inactive lanes of `bus_wdata` are 0.
- R7: For reads, `rd_data` holds every requested byte gathered from the beats, with all other bytes 0. For writes, `rd_data` is 0.
- R8: A beat holds its address, lanes and data unchanged until `bus_ack` is sampled high.
- R9: On writes, `bus_wpar[k]` makes the count of ones in lane k plus its parity bit odd when `par_odd` = 1 and even when `par_odd` = 0, for every active lane. Inactive lanes carry parity 0. The parity sense is taken from the request at acceptance.
- R10: On read beats, parity is checked only on the active lanes. A mismatch sets `par_err` and ORs the failing lanes into `par_err_lanes`. Both stay set until the next request is accepted, which clears them.
- R11: `done` is a single-cycle pulse in the cycle after the final beat's acknowledge. `bus_valid` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size code |
| req_addr | input | AW | Request byte address |
| req_wdata | input | 32 | Write data, word-lane aligned |
| port_width | input | 2 | Width code of addressed port |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| bus_valid | output | 1 | Beat in progress |
| bus_write | output | 1 | Beat direction |
| bus_addr | output | AW | Beat address |
| bus_lanes | output | 4 | Active byte lanes |
| bus_wdata | output | 32 | Steered write data |
| bus_wpar | output | 4 | Write parity per lane |
| bus_ack | input | 1 | Beat acknowledge |
| bus_rdata | input | 32 | Read data from port |
| bus_rpar | input | 4 | Read parity per lane |
| done | output | 1 | Transfer complete pulse |
| rd_data | output | 32 | Assembled read data |
| par_err | output | 1 | Sticky parity error |
| par_err_lanes | output | 4 | Accumulated failing lanes |

## Verification
The bench aims at the narrow-port cases where lane mapping is easiest to get wrong: halfwords and bytes at odd offsets on 8- and 16-bit ports, and a misaligned word address that must be realigned. A design that mixes up lane and offset would return bytes in swapped positions or drive the wrong lane mask. During read beats, the emulated port drives unused lanes with deliberately wrong parity. A checker that looked at inactive lanes would raise a false error. Wait cycles carrying a stray request test that the beat holds and the request is ignored. A single flipped parity bit must set the matching lane bit, survive later clean beats and clear on the next request; getting this wrong would either lose the flag or let it leak into the next transfer.

// File: rtl/dbus_sizer_pkg.sv
package dbus_sizer_pkg;

    localparam int DATA_W   = 32;
    localparam int NLANES   = DATA_W / 8;
    localparam int LANE_IDX = $clog2(NLANES);

    // Byte count for a size / port-width code: 0 -> 1, 1 -> 2, else 4.
    function automatic logic [2:0] bytes_of(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    typedef struct packed {
        logic                busy;
        logic                write;
        logic [1:0]          size;
        logic [1:0]          pw;
        logic                odd;
        logic [31:0]         addr;
        logic [DATA_W-1:0]   wdata;
        logic [1:0]          beat;
        logic [DATA_W-1:0]   rbuf;
        logic                done;
        logic [DATA_W-1:0]   rd;
        logic                err;
        logic [NLANES-1:0]   elanes;
    } sizer_state_t;

endpackage

// File: rtl/dbus_beat_plan.sv
module dbus_beat_plan
    import dbus_sizer_pkg::*;
(
    input  logic [1:0]               size_code,
    input  logic [1:0]               port_code,
    input  logic [1:0]               base_off,
    input  logic [1:0]               beat_idx,
    output logic [NLANES-1:0]        lane_mask,
    output logic [NLANES*2-1:0]      lane_src,
    output logic [1:0]               beat_off,
    output logic                     last_beat
);

    logic [2:0] nbytes;
    logic [2:0] pbytes;
    logic [2:0] per_beat;
    logic [3:0] start_off;

    always_comb begin
        nbytes    = bytes_of(size_code);
        pbytes    = bytes_of(port_code);
        per_beat  = (nbytes < pbytes) ? nbytes : pbytes;
        start_off = {2'b00, base_off} + ({2'b00, beat_idx} * {1'b0, pbytes});
        last_beat = ((({2'b00, beat_idx} + 4'd1) * {1'b0, per_beat}) >= {1'b0, nbytes});
        beat_off  = start_off[1:0];
        lane_mask = '0;
        lane_src  = '0;
        for (int o = 0; o < NLANES; o++) begin
            if ((4'(o) >= start_off) && (4'(o) < start_off + {1'b0, per_beat})) begin
                lane_mask[(NLANES-1) - (o % int'(pbytes))] = 1'b1;
                lane_src[((NLANES-1) - (o % int'(pbytes)))*2 +: 2] = 2'((NLANES-1) - o);
            end
        end
    end

endmodule

// File: rtl/dbus_lane_parity.sv
module dbus_lane_parity
    import dbus_sizer_pkg::*;
(
    input  logic [DATA_W-1:0]  wr_bytes,
    input  logic [DATA_W-1:0]  rd_bytes,
    input  logic [NLANES-1:0]  rd_par,
    input  logic [NLANES-1:0]  active,
    input  logic               odd_sel,
    input  logic               chk_en,
    output logic [NLANES-1:0]  wr_par,
    output logic [NLANES-1:0]  mismatch
);

    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        assign wr_par[k]   = active[k] & ((^wr_bytes[k*8 +: 8]) ^ odd_sel);
        assign mismatch[k] = chk_en & active[k]
                             & (((^rd_bytes[k*8 +: 8]) ^ rd_par[k]) != odd_sel);
    end

endmodule

// File: rtl/dbus_sizer.sv
module dbus_sizer
    import dbus_sizer_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [AW-1:0]      req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [1:0]         port_width,
    input  logic               par_odd,
    output logic               bus_valid,
    output logic               bus_write,
    output logic [AW-1:0]      bus_addr,
    output logic [3:0]         bus_lanes,
    output logic [31:0]        bus_wdata,
    output logic [3:0]         bus_wpar,
    input  logic               bus_ack,
    input  logic [31:0]        bus_rdata,
    input  logic [3:0]         bus_rpar,
    output logic               done,
    output logic [31:0]        rd_data,
    output logic               par_err,
    output logic [3:0]         par_err_lanes
);

    sizer_state_t st_d, st_q;

    logic [NLANES-1:0]   beat_lanes;
    logic [NLANES*2-1:0] beat_src;
    logic [1:0]          beat_off;
    logic                beat_last;
    logic [NLANES-1:0]   lane_bad;
    logic [DATA_W-1:0]   steered;
    logic [AW-1:0]       aligned_addr;

    dbus_beat_plan u_plan (
        .size_code (st_q.size),
        .port_code (st_q.pw),
        .base_off  (st_q.addr[1:0]),
        .beat_idx  (st_q.beat),
        .lane_mask (beat_lanes),
        .lane_src  (beat_src),
        .beat_off  (beat_off),
        .last_beat (beat_last)
    );

    // Write steering: each active bus lane takes the request byte it maps to.
    always_comb begin
        steered = '0;
        for (int k = 0; k < NLANES; k++) begin
            if (beat_lanes[k] && st_q.busy)
                steered[k*8 +: 8] = st_q.wdata[int'(beat_src[k*2 +: 2])*8 +: 8];
        end
    end

    dbus_lane_parity u_par (
        .wr_bytes (steered),
        .rd_bytes (bus_rdata),
        .rd_par   (bus_rpar),
        .active   (st_q.busy ? beat_lanes : '0),
        .odd_sel  (st_q.odd),
        .chk_en   (st_q.busy & ~st_q.write & bus_ack),
        .wr_par   (bus_wpar),
        .mismatch (lane_bad)
    );

    always_comb begin
        case (req_size)
            2'd0:    aligned_addr = req_addr;
            2'd1:    aligned_addr = {req_addr[AW-1:1], 1'b0};
            default: aligned_addr = {req_addr[AW-1:2], 2'b00};
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy   = 1'b1;
                st_d.write  = req_write;
                st_d.size   = req_size;
                st_d.pw     = port_width;
                st_d.odd    = par_odd;
                st_d.addr   = 32'(aligned_addr);
                st_d.wdata  = req_wdata;
                st_d.beat   = 2'd0;
                st_d.rbuf   = '0;
                st_d.err    = 1'b0;
                st_d.elanes = '0;
            end
        end else if (bus_ack) begin
            for (int k = 0; k < NLANES; k++) begin
                if (beat_lanes[k] && !st_q.write)
                    st_d.rbuf[int'(beat_src[k*2 +: 2])*8 +: 8] = bus_rdata[k*8 +: 8];
            end
            if (|lane_bad) begin
                st_d.err    = 1'b1;
                st_d.elanes = st_q.elanes | lane_bad;
            end
            if (beat_last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.rd   = st_q.write ? '0 : st_d.rbuf;
            end else begin
                st_d.beat = st_q.beat + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_valid     = st_q.busy;
    assign bus_write     = st_q.write;
    assign bus_addr      = AW'({st_q.addr[31:2], beat_off});
    assign bus_lanes     = st_q.busy ? beat_lanes : '0;
    assign bus_wdata     = st_q.write ? steered : '0;
    assign done          = st_q.done;
    assign rd_data       = st_q.rd;
    assign par_err       = st_q.err;
    assign par_err_lanes = st_q.elanes;

    // Assertions
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_valid);

    assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_lanes)
                                      && $stable(bus_wdata)));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !(req_valid && !bus_valid)) |=> par_err);

    assert_lane_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_lanes != 4'b0) &&
                      ($countones(bus_lanes) <= int'(bytes_of(st_q.pw))));

    assert_idle_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (bus_lanes == 4'b0));

endmodule

// File: tb/dbus_sizer_tb_top.sv
`timescale 1ns/1ps
module dbus_sizer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, par_odd = 1'b0;
    logic [1:0]  req_size = 2'd0, port_width = 2'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        bus_valid, bus_write, done, par_err;
    logic [31:0] bus_addr, bus_wdata, rd_data;
    logic [3:0]  bus_lanes, bus_wpar, par_err_lanes;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic [3:0]  bus_rpar = '0;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dbus_sizer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .port_width(port_width), .par_odd(par_odd), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_lanes(bus_lanes),
        .bus_wdata(bus_wdata), .bus_wpar(bus_wpar), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .bus_rpar(bus_rpar), .done(done),
        .rd_data(rd_data), .par_err(par_err), .par_err_lanes(par_err_lanes)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [1:0]  pw;
        logic        odd;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [2:0]  beats;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd2, 2'd0, 1'b1, 8'h10, 32'h0,           3'd4},
        '{1'b0, 2'd2, 2'd1, 1'b0, 8'h24, 32'h0,           3'd2},
        '{1'b0, 2'd2, 2'd2, 1'b1, 8'h38, 32'h0,           3'd1},
        '{1'b0, 2'd1, 2'd0, 1'b0, 8'h42, 32'h0,           3'd2},
        '{1'b0, 2'd1, 2'd2, 1'b1, 8'h56, 32'h0,           3'd1},
        '{1'b0, 2'd0, 2'd1, 1'b1, 8'h63, 32'h0,           3'd1},
        '{1'b1, 2'd2, 2'd0, 1'b0, 8'h70, 32'h11223344,    3'd4},
        '{1'b1, 2'd2, 2'd1, 1'b1, 8'h80, 32'hA1B2C3D4,    3'd2},
        '{1'b1, 2'd1, 2'd1, 1'b0, 8'h92, 32'h0000BEEF,    3'd1},
        '{1'b1, 2'd0, 2'd2, 1'b1, 8'hA1, 32'h00770000,    3'd1},
        '{1'b1, 2'd1, 2'd0, 1'b1, 8'hB0, 32'h5A6B0000,    3'd2},
        '{1'b0, 2'd0, 2'd0, 1'b0, 8'hC3, 32'h0,           3'd1},
        '{1'b0, 2'd2, 2'd2, 1'b0, 8'hD6, 32'h0,           3'd1}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ 8'h5C;
    endfunction

    function automatic int nbytes(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    // One transfer with the bench acting as the addressed port.
    task automatic run_xfer(input bit wr, input logic [1:0] sz, input logic [1:0] pw,
                            input bit odd, input logic [31:0] addr, input logic [31:0] wdata,
                            input int beats, input logic [3:0] inj, input int waits,
                            input bit stray);
        int nb, pb, per, a0;
        logic [31:0] base, ba, ew, exp_rd;
        logic [3:0]  el, ep;
        nb   = nbytes(sz);
        pb   = nbytes(pw);
        per  = (nb < pb) ? nb : pb;
        base = addr & ~(32'(nb) - 32'd1);
        a0   = int'(base[1:0]);

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; port_width = pw;
        par_odd = odd; req_addr = addr; req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        check(bus_valid === 1'b1, "R2 first beat after accept", 32'(bus_valid), 32'd1);
        check(par_err === 1'b0 && par_err_lanes === 4'd0, "R10 cleared on accept",
              {28'd0, par_err_lanes}, 32'd0);

        for (int j = 0; j < beats; j++) begin
            ba = base + 32'(j * pb);
            el = '0; ew = '0; ep = '0;
            for (int o = a0 + j * pb; o < a0 + j * pb + per; o++) begin
                el[3 - (o % pb)] = 1'b1;
                ew[(3 - (o % pb))*8 +: 8] = wdata[(3 - o)*8 +: 8];
            end
            for (int k = 0; k < 4; k++)
                if (el[k]) ep[k] = (^ew[k*8 +: 8]) ^ odd;
            for (int w = 0; w < waits; w++) begin
                if (stray) begin
                    req_valid = 1'b1; req_addr = 32'hFFFF_FF00; req_size = 2'd0;
                end
                @(negedge clk);
                req_valid = 1'b0;
                check(bus_valid === 1'b1 && bus_addr === ba, "R8 beat held during wait",
                      bus_addr, ba);
                check(bus_lanes === el, "R2 stray request ignored", {28'd0, bus_lanes},
                      {28'd0, el});
            end
            check(bus_addr === ba, "R4 beat address", bus_addr, ba);
            check(bus_lanes === el, "R5 lane mask", {28'd0, bus_lanes}, {28'd0, el});
            if (wr) begin
                check(bus_wdata === ew, "R6 write steering", bus_wdata, ew);
                check(bus_wpar === ep, "R9 write parity", {28'd0, bus_wpar}, {28'd0, ep});
            end
            for (int i = 0; i < 4; i++) begin
                logic [7:0] b;
                if (i < pb) begin
                    b = mem_byte((ba & ~(32'(pb) - 32'd1)) + 32'(i));
                    bus_rdata[(3 - i)*8 +: 8] = b;
                    bus_rpar[3 - i] = (^b) ^ odd ^ ((j == 0) ? inj[3 - i] : 1'b0);
                end else begin
                    bus_rdata[(3 - i)*8 +: 8] = 8'hEE;
                    bus_rpar[3 - i] = (^8'hEE) ^ odd ^ 1'b1;
                end
            end
            bus_ack = 1'b1;
            @(negedge clk);
            bus_ack = 1'b0;
        end

        exp_rd = '0;
        if (!wr)
            for (int o = a0; o < a0 + nb; o++)
                exp_rd[(3 - o)*8 +: 8] = mem_byte({addr[31:2], 2'b00} + 32'(o));
        check(done === 1'b1, "R3 beat count / R11 done after last ack", 32'(done), 32'd1);
        check(bus_valid === 1'b0, "R11 bus idle with done", 32'(bus_valid), 32'd0);
        check(rd_data === exp_rd, "R7 assembled read data", rd_data, exp_rd);
        check(par_err === (|inj) && par_err_lanes === inj, "R10 error lanes",
              {27'd0, par_err, par_err_lanes}, {27'd0, |inj, inj});
        @(negedge clk);
        check(done === 1'b0, "R11 done single cycle", 32'(done), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bus_valid === 1'b0 && done === 1'b0, "R1 reset outputs", {30'd0, bus_valid, done}, 32'd0);
        check(par_err === 1'b0 && par_err_lanes === 4'd0 && bus_lanes === 4'd0, "R1 reset flags",
              {23'd0, par_err, par_err_lanes, bus_lanes}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_valid === 1'b0 && done === 1'b0, "R1 idle after reset",
              {30'd0, bus_valid, done}, 32'd0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            run_xfer(VECS[v].wr, VECS[v].sz, VECS[v].pw, VECS[v].odd,
                     {24'h000100, VECS[v].addr}, VECS[v].wdata, int'(VECS[v].beats),
                     4'd0, 0, 1'b0);
        end

        // R8 / R2: wait states with stray requests on a 16-bit word write
        run_xfer(1'b1, 2'd2, 2'd1, 1'b0, 32'h0000_0200, 32'hCAFE_F00D, 2, 4'd0, 3, 1'b1);

        // R10: flipped parity on lane 3 of the first beat, sticky through clean beat 2
        run_xfer(1'b0, 2'd2, 2'd1, 1'b1, 32'h0000_0300, 32'h0, 2, 4'b1000, 0, 1'b0);
        // R10: error stays after done until next accept, then clears
        @(negedge clk);
        check(par_err === 1'b1, "R10 sticky while idle", 32'(par_err), 32'd1);
        run_xfer(1'b0, 2'd1, 2'd0, 1'b0, 32'h0000_0312, 32'h0, 2, 4'd0, 1, 1'b0);

        // R10: error on an odd-offset byte through the 16-bit port (lane 2)
        run_xfer(1'b0, 2'd0, 2'd1, 1'b0, 32'h0000_0401, 32'h0, 1, 4'b0100, 0, 1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule